// File: doc/BRIEF.md
# Translation Buffer with Access-Right Checking

This block keeps a small, fully associative set of recent virtual-to-physical page translations. A lookup presents a 32-bit virtual address, a read/write flag and a privilege flag. In the same cycle, combinationally, it reports one of three outcomes. A hit that is permitted returns the physical address. A hit whose rights deny the access raises a fault. When no valid entry holds the page, the block reports a miss. The page offset is 12 bits, so pages are 4 KB.

After a miss, an external table walker fetches the mapping and installs it through the refill port. The access is then retried. Each entry holds a valid flag, a readable flag, a writable flag, a user-accessible flag, a dirty flag, the virtual page tag and the physical page number. A permitted write marks its entry dirty. The refill port picks the slot to overwrite. A flush input empties the buffer in one cycle.

Top module: `xlate_buf`

## Requirements
- R1: After reset, and in the cycle after `flush_i` is high, every lookup misses.
- R2: A permitted hit drives `hit_o`=1, `miss_o`=0, `fault_o`=0. In the same cycle it drives `pa_o` = {stored physical page number, `va_i[11:0]`}.
- R3: A lookup (`req_i`=1) whose page `va_i[31:12]` matches no valid entry drives `miss_o`=1, `hit_o`=0, `fault_o`=0 and `pa_o`=0.
- R4: A hit whose read (`wr_i`=0) or write (`wr_i`=1) right is clear drives `hit_o`=1, `fault_o`=1 and `pa_o`=0.
- R5: When `user_i`=1, a hit on an entry whose user flag is clear faults. When `user_i`=0, the user flag is ignored and only the read/write rights apply.
- R6: A permitted write hit sets the entry's dirty flag. A faulting write leaves it clear. `dirty_o` shows the matched entry's dirty flag on every hit.
- R7: A refill whose page already sits in a valid entry overwrites that entry and no other.
- R8: Otherwise, a refill goes into the lowest-numbered invalid slot and leaves the replacement pointer unchanged.
- R9: When every slot is valid, a refill overwrites the slot named by the replacement pointer. That pointer starts at 0 after reset and then advances by one, wrapping modulo the entry count.
- R10: When `flush_i` and `fill_i` are high in the same cycle, the flush wins and nothing is installed.
- R11: With `req_i`=0, `hit_o`, `miss_o`, `fault_o`, `dirty_o` and `pa_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Virtual address |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| user_i | input | 1 | 1 = user privilege, 0 = kernel |
| hit_o | output | 1 | Valid entry matched |
| miss_o | output | 1 | No valid entry matched |
| fault_o | output | 1 | Match found but access denied |
| dirty_o | output | 1 | Dirty flag of matched entry |
| pa_o | output | 32 | Physical address on permitted hit, else 0 |
| fill_i | input | 1 | Install an entry |
| fill_vpn_i | input | 20 | Virtual page of the new entry |
| fill_ppn_i | input | 20 | Physical page of the new entry |
| fill_rd_i | input | 1 | Readable flag |
| fill_wr_i | input | 1 | Writable flag |
| fill_usr_i | input | 1 | User-accessible flag |
| fill_dirty_i | input | 1 | Initial dirty flag |

## Verification
The hardest state to reach from the ports is a slot choice where a free-slot-first policy and a pure pointer policy give different victims. The stimulus reaches it in several steps. First it advances the pointer to 2 with two evictions. Then it flushes and refills all eight slots. A ninth refill follows, and the bench then checks which of the earlier pages was lost. A duplicate-page refill is issued while free slots remain. This separates overwrite-in-place from a fresh allocation.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic usr;
  } xlate_attr_t;
  localparam int ATTR_W = $bits(xlate_attr_t);
endpackage

// File: rtl/xlate_cam.sv
module xlate_cam #(
  parameter int N      = 8,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic [N-1:0]      match_o,
  output logic [DATA_W-1:0] lk_data_o,
  output logic              lk_dirty_o,
  input  logic              set_dirty_i,
  input  logic [N-1:0]      fill_sel_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_dirty_i,
  output logic [N-1:0]      fill_match_o,
  output logic [N-1:0]      valid_o
);
  logic [N-1:0]      valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [N];
  logic [DATA_W-1:0] data_q [N];

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g]      = valid_q[g] && (tag_q[g] == lk_tag_i);
    assign fill_match_o[g] = valid_q[g] && (tag_q[g] == fill_tag_i);
  end

  always_comb begin
    lk_data_o  = '0;
    lk_dirty_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) begin
        lk_data_o  = lk_data_o | data_q[i];
        lk_dirty_o = lk_dirty_o | dirty_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else valid_q <= valid_q | fill_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (fill_sel_i[i]) begin
          tag_q[i]   <= fill_tag_i;
          data_q[i]  <= fill_data_i;
          dirty_q[i] <= fill_dirty_i;
        end else if (set_dirty_i && match_o[i]) begin
          dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R1
  AST_MATCH_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o)); // R7
  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_dirty_i && ((fill_sel_i & match_o) == '0) && (match_o != '0))
      |=> ((dirty_q & $past(match_o)) != '0)); // R6
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_i,
  input  logic         flush_i,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] fill_match_i,
  output logic [N-1:0] fill_sel_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q, free_idx, dup_idx, sel_idx;
  logic             free_any, dup_any, fill_ok, use_ptr;

  always_comb begin
    free_idx = '0;
    dup_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i])     free_idx = IDX_W'(i);
      if (fill_match_i[i]) dup_idx  = IDX_W'(i);
    end
  end

  assign free_any = ~&valid_i;
  assign dup_any  = |fill_match_i;
  assign fill_ok  = fill_i && !flush_i;
  assign use_ptr  = fill_ok && !dup_any && !free_any;
  assign sel_idx  = dup_any ? dup_idx : (free_any ? free_idx : ptr_q);

  always_comb begin
    fill_sel_o = '0;
    fill_sel_o[sel_idx] = fill_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (use_ptr) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  AST_ONE_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_sel_o)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_ptr |=> $stable(ptr_q)); // R8
  if (N > 1) begin : g_ptr_chk
    AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      use_ptr |=> (ptr_q != $past(ptr_q))); // R9
  end
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
(
  input  logic        hit_i,
  input  logic        wr_i,
  input  logic        user_i,
  input  xlate_attr_t attr_i,
  output logic        fault_o
);
  logic rw_deny, priv_deny;
  assign rw_deny   = wr_i ? !attr_i.wr : !attr_i.rd;
  assign priv_deny = user_i && !attr_i.usr;
  assign fault_o   = hit_i && (rw_deny || priv_deny);
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   req_i,
  input  logic [VA_W-1:0]        va_i,
  input  logic                   wr_i,
  input  logic                   user_i,
  output logic                   hit_o,
  output logic                   miss_o,
  output logic                   fault_o,
  output logic                   dirty_o,
  output logic [PA_W-1:0]        pa_o,
  input  logic                   fill_i,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn_i,
  input  logic [PA_W-OFF_W-1:0]  fill_ppn_i,
  input  logic                   fill_rd_i,
  input  logic                   fill_wr_i,
  input  logic                   fill_usr_i,
  input  logic                   fill_dirty_i
);
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int DATA_W = PPN_W + ATTR_W;

  logic [N-1:0]      match, fill_match, valid, fill_sel;
  logic [DATA_W-1:0] hit_data, fill_data;
  logic              hit_dirty, hit, fault, set_dirty;
  logic [PPN_W-1:0]  hit_ppn;
  xlate_attr_t       hit_attr, fill_attr;

  assign fill_attr = '{rd: fill_rd_i, wr: fill_wr_i, usr: fill_usr_i};
  assign fill_data = {fill_ppn_i, fill_attr};

  xlate_cam #(.N(N), .TAG_W(VPN_W), .DATA_W(DATA_W)) u_cam (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .lk_tag_i     (va_i[VA_W-1:OFF_W]),
    .match_o      (match),
    .lk_data_o    (hit_data),
    .lk_dirty_o   (hit_dirty),
    .set_dirty_i  (set_dirty),
    .fill_sel_i   (fill_sel),
    .fill_tag_i   (fill_vpn_i),
    .fill_data_i  (fill_data),
    .fill_dirty_i (fill_dirty_i),
    .fill_match_o (fill_match),
    .valid_o      (valid)
  );

  xlate_victim #(.N(N)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_i       (fill_i),
    .flush_i      (flush_i),
    .valid_i      (valid),
    .fill_match_i (fill_match),
    .fill_sel_o   (fill_sel)
  );

  assign {hit_ppn, hit_attr} = hit_data;
  assign hit = req_i && (match != '0);

  xlate_perm u_perm (
    .hit_i   (hit),
    .wr_i    (wr_i),
    .user_i  (user_i),
    .attr_i  (hit_attr),
    .fault_o (fault)
  );

  // mark only clean entries to avoid redundant writes
  assign set_dirty = hit && !fault && wr_i && !hit_dirty;

  assign hit_o   = hit;
  assign miss_o  = req_i && !hit;
  assign fault_o = fault;
  assign dirty_o = hit && hit_dirty;
  assign pa_o    = (hit && !fault) ? {hit_ppn, va_i[OFF_W-1:0]} : '0;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R3
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (hit_o && pa_o == '0)); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !fault_o) |-> (pa_o[OFF_W-1:0] == va_i[OFF_W-1:0])); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(hit_o || miss_o || fault_o || dirty_o)); // R11
  AST_KERNEL_RW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !user_i && (wr_i ? hit_attr.wr : hit_attr.rd)) |-> !fault_o); // R5
endmodule

// File: tb/xlate_buf_bench.sv
module xlate_buf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, req_i = 1'b0, wr_i = 1'b0, user_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        hit_o, miss_o, fault_o, dirty_o;
  logic [31:0] pa_o;
  logic        fill_i = 1'b0, fill_rd_i = 1'b0, fill_wr_i = 1'b0;
  logic        fill_usr_i = 1'b0, fill_dirty_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_ppn_i = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  xlate_buf u_xlate_buf (.*);

  // {va, wr, user, exp_hit, exp_fault, exp_pa}
  localparam logic [67:0] VEC [8] = '{
    {32'h0001_0123, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0ABC_D123}, // R2
    {32'h0002_0FFF, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0},         // R4 no write right
    {32'h0002_0000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_5000}, // R2
    {32'h0003_0456, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0},         // R5 user on kernel page
    {32'h0003_0456, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0F00_F456}, // R5 kernel ok
    {32'hFFFF_F001, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0},         // R4 no read right
    {32'hFFFF_F001, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_E001}, // R2 write-only
    {32'h0004_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0}          // R3
  };

  task automatic report(input string req, input string what, input logic [31:0] got,
                        input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic usr,
                      input logic eh, input logic ef, input logic [31:0] epa,
                      input string req);
    @(negedge clk_i);
    req_i = 1'b1; va_i = va; wr_i = wr; user_i = usr;
    #1;
    report(req, "flags{hit,miss,fault}", {29'b0, hit_o, miss_o, fault_o},
           {29'b0, eh, !eh, ef});
    report(req, "pa", pa_o, epa);
  endtask

  task automatic look_dirty(input logic [31:0] va, input logic ed, input string req);
    @(negedge clk_i);
    req_i = 1'b1; va_i = va; wr_i = 1'b0; user_i = 1'b0;
    #1;
    report(req, "dirty", {31'b0, dirty_o}, {31'b0, ed});
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic rd,
                      input logic wr, input logic usr, input logic dty, input logic fl);
    @(negedge clk_i);
    req_i = 1'b0;
    fill_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn;
    fill_rd_i = rd; fill_wr_i = wr; fill_usr_i = usr; fill_dirty_i = dty; flush_i = fl;
    @(negedge clk_i);
    fill_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk_i);
    req_i = 1'b0; flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    look(32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R1"); // empty after reset

    fill(20'h00010, 20'h0ABCD, 1, 1, 1, 0, 0);
    fill(20'h00020, 20'h12345, 1, 0, 1, 0, 0);
    fill(20'h00030, 20'h0F00F, 1, 1, 0, 1, 0);
    fill(20'hFFFFF, 20'hFFFFE, 0, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++)
      look(VEC[i][67:36], VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0],
           "R2/R3/R4/R5 vector");

    // R6 dirty marking
    look_dirty(32'h0001_0000, 1'b0, "R6");
    look(32'h0001_0010, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0ABC_D010, "R6");
    look_dirty(32'h0001_0000, 1'b1, "R6");
    look(32'h0002_0010, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0, "R6");
    look_dirty(32'h0002_0000, 1'b0, "R6");
    look_dirty(32'hFFFF_F000, 1'b1, "R6");

    // R7 duplicate page overwrites in place while free slots exist
    fill(20'h00010, 20'h00777, 1, 1, 1, 0, 0);
    look(32'h0001_0ABC, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0077_7ABC, "R7");
    look_dirty(32'h0001_0000, 1'b0, "R7");
    for (int i = 0; i < 4; i++) fill(20'h00100 + 20'(i), 20'h00100 + 20'(i), 1, 1, 1, 0, 0);
    // R9 full: pointer slot 0 then 1
    fill(20'h00200, 20'h00200, 1, 1, 1, 0, 0);
    look(32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R9");
    look(32'h0002_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5000, "R9");
    look(32'h0020_0008, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0020_0008, "R9");
    fill(20'h00201, 20'h00201, 1, 1, 1, 0, 0);
    look(32'h0002_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R9");
    look(32'h0003_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0F00_F000, "R9");

    flush();
    look(32'h0020_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R1");
    look(32'h0003_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R1");

    // R8 free slots first, pointer left at 2
    for (int i = 0; i < 8; i++) fill(20'h00300 + 20'(i), 20'h00A00 + 20'(i), 1, 1, 1, 0, 0);
    fill(20'h00308, 20'h00A08, 1, 1, 1, 0, 0);
    look(32'h0030_2000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R8");
    look(32'h0030_0004, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00A0_0004, "R8");
    look(32'h0030_1000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00A0_1000, "R8");
    look(32'h0030_8FFF, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00A0_8FFF, "R9");

    // R11 idle
    @(negedge clk_i);
    req_i = 1'b0; va_i = 32'h0030_0000;
    #1;
    report("R11", "idle outputs", {27'b0, hit_o, miss_o, fault_o, dirty_o, |pa_o}, 32'h0);

    // R10 flush beats fill
    fill(20'h00400, 20'h00400, 1, 1, 1, 0, 1);
    look(32'h0040_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R10");
    look(32'h0030_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule